// File: doc/BRIEF.md
# Masked Serial Address Recognizer

This block sits behind the bit-level receiver of a serial port that shares one line among several nodes. Each time the receiver finishes a frame it presents the received byte and one extra bit to the recognizer. In nine-bit format that bit marks an address frame. In stop-bit format it is the captured stop bit. When multiprocessor filtering is enabled, the recognizer raises the receive flag only for frames that concern this node. Data frames in nine-bit format are never filtered. Address frames must hit either the node's given address or its broadcast address. With filtering disabled, every completed frame raises the flag.

The node identity is two stored bytes, loaded through a plain load strobe. The first is an individual address. The second is a mask whose zero bits are don't-care positions. By picking the mask, software can make the node answer to its own address alone or to a group of addresses shared with other nodes. The broadcast address is the OR of address and mask. A received byte hits it when the byte has a one in every position where that OR has a one. Both stored bytes clear to zero at reset, so a freshly reset node accepts any address.

Frames arrive on a valid/ready stream. The recognizer consumes a frame in the cycle it is presented, so ready is held high and there is never back-pressure. A frame counts as delivered on any rising clock edge where valid and ready are both high. The receive flag is a one-cycle pulse in the cycle that follows that edge.

Top module: `sar_addr_filter`

## Requirements
- R1: After reset, rx_flag is 0 and the stored address and mask are 00h, so an address frame carrying any byte raises rx_flag.
- R2: With mp_en = 0, every delivered frame raises rx_flag, whatever the value of frm_tag and frm_fmt.
- R3: With mp_en = 1 and frm_fmt = 0 (nine-bit format), a frame with frm_tag = 0 is a data frame and raises rx_flag whatever its byte.
- R4: For an address frame with mp_en = 1, the given address hits when ((frm_byte ^ addr) & mask) == 0. Positions where the mask is 0 are don't-care.
- R5: With a mask of FFh, the given address hits only when frm_byte equals the stored address exactly.
- R6: The broadcast address is addr | mask. An address frame also hits when frm_byte has a 1 in every bit position where addr | mask has a 1. An address frame that hits neither the given nor the broadcast address leaves rx_flag at 0.
- R7: With mp_en = 1 and frm_fmt = 1 (stop-bit format), frm_tag is the stop bit. rx_flag rises only when the byte hits and frm_tag = 1. A frame with frm_tag = 0 never raises it.
- R8: rx_flag is high for exactly the one cycle after a delivering edge whose frame passes, and 0 in every cycle after an edge with no delivered frame.
- R9: frm_ready is 1 whenever reset is released. The block never back-pressures the frame stream.
- R10: A node_load at the same edge as a delivered frame changes the stored address and mask for later frames only. That frame is judged against the previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mp_en | input | 1 | Multiprocessor filtering enable |
| frm_fmt | input | 1 | 0 = nine-bit format, 1 = stop-bit format |
| node_load | input | 1 | Loads node_addr_d and node_mask_d into the stored identity |
| node_addr_d | input | DATA_W | Individual address to load |
| node_mask_d | input | DATA_W | Mask to load (0 = don't-care) |
| frm_valid | input | 1 | Frame present on the stream |
| frm_ready | output | 1 | Frame accepted (always 1 out of reset) |
| frm_byte | input | DATA_W | Received byte |
| frm_tag | input | 1 | Ninth bit (nine-bit format) or stop bit (stop-bit format) |
| rx_flag | output | 1 | Receive flag pulse for a frame that passes the filter |

## Verification
The given-address compare is tried with an exact mask of FFh and with a mask that frees the low nibble. Hits in the free nibble separate correct don't-care handling from exact compare. A miss in the upper nibble shows the mask is not ignored. Bytes that miss the given address but set every bit of addr | mask (F4h, F7h, FFh) separate the broadcast path from the given path. A byte missing one of those bits shows the broadcast compare is not a plain wildcard. Stop-bit frames with the stop bit low and high, data frames, frames with filtering disabled, and a load in the same cycle as a frame separate the gating rules and the timing of the stored identity.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    FMT_NINE_BIT = 1'b0,
    FMT_STOP_BIT = 1'b1
  } sar_fmt_e;
endpackage

// File: rtl/sar_node_regs.sv
module sar_node_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] addr_d,
  input  logic [DATA_W-1:0] mask_d,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mask_q <= '0;
    end else if (load) begin
      addr_q <= addr_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/sar_addr_cmp.sv
module sar_addr_cmp #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [DATA_W-1:0] addr,
  input  logic [DATA_W-1:0] mask,
  output logic              given_hit,
  output logic              bcast_hit
);
  logic [DATA_W-1:0] given_ok;
  logic [DATA_W-1:0] bcast_ok;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    // a masked-in position must agree with the stored address
    assign given_ok[i] = !mask[i] || (rx_byte[i] == addr[i]);
    // a position set in addr|mask must be set in the received byte
    assign bcast_ok[i] = rx_byte[i] || !(addr[i] || mask[i]);
  end

  assign given_hit = &given_ok;
  assign bcast_hit = &bcast_ok;
endmodule

// File: rtl/sar_frame_gate.sv
module sar_frame_gate
  import sar_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     take,
  input  logic     mp_en,
  input  sar_fmt_e fmt,
  input  logic     tag,
  input  logic     given_hit,
  input  logic     bcast_hit,
  output logic     flag
);
  logic addr_hit;
  logic pass;

  assign addr_hit = given_hit || bcast_hit;

  always_comb begin
    if (!mp_en) begin
      pass = 1'b1;
    end else if (fmt == FMT_NINE_BIT) begin
      pass = !tag || addr_hit;
    end else begin
      pass = tag && addr_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= take && pass;
  end
endmodule

// File: rtl/sar_addr_filter.sv
module sar_addr_filter
  import sar_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mp_en,
  input  logic              frm_fmt,
  input  logic              node_load,
  input  logic [DATA_W-1:0] node_addr_d,
  input  logic [DATA_W-1:0] node_mask_d,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [DATA_W-1:0] frm_byte,
  input  logic              frm_tag,
  output logic              rx_flag
);
  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] mask_q;
  logic              given_hit;
  logic              bcast_hit;
  logic              take;

  assign frm_ready = 1'b1;
  assign take      = frm_valid && frm_ready;

  sar_node_regs #(.DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (node_load),
    .addr_d (node_addr_d),
    .mask_d (node_mask_d),
    .addr_q (addr_q),
    .mask_q (mask_q)
  );

  sar_addr_cmp #(.DATA_W(DATA_W)) u_cmp (
    .rx_byte   (frm_byte),
    .addr      (addr_q),
    .mask      (mask_q),
    .given_hit (given_hit),
    .bcast_hit (bcast_hit)
  );

  sar_frame_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .mp_en     (mp_en),
    .fmt       (sar_fmt_e'(frm_fmt)),
    .tag       (frm_tag),
    .given_hit (given_hit),
    .bcast_hit (bcast_hit),
    .flag      (rx_flag)
  );
endmodule

// File: rtl/sar_addr_filter_chk.sv
module sar_addr_filter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mp_en,
  input logic              frm_fmt,
  input logic              frm_valid,
  input logic              frm_ready,
  input logic [DATA_W-1:0] frm_byte,
  input logic              frm_tag,
  input logic [DATA_W-1:0] addr_q,
  input logic [DATA_W-1:0] mask_q,
  input logic              rx_flag
);
  logic take;
  assign take = frm_valid && frm_ready;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (addr_q == '0 && mask_q == '0 && !rx_flag));

  // R2
  open_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !mp_en) |=> rx_flag);

  // R3
  data_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mp_en && !frm_fmt && !frm_tag) |=> rx_flag);

  // R5
  exact_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mp_en && frm_tag && mask_q == '1 && frm_byte == addr_q) |=> rx_flag);

  // R7
  bad_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mp_en && frm_fmt && !frm_tag) |=> !rx_flag);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !rx_flag);

  // R9
  no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> frm_ready);
endmodule

bind sar_addr_filter sar_addr_filter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mp_en     (mp_en),
  .frm_fmt   (frm_fmt),
  .frm_valid (frm_valid),
  .frm_ready (frm_ready),
  .frm_byte  (frm_byte),
  .frm_tag   (frm_tag),
  .addr_q    (addr_q),
  .mask_q    (mask_q),
  .rx_flag   (rx_flag)
);

// File: tb/sim_sar_addr_filter.sv
module sim_sar_addr_filter;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mp_en = 1'b0;
  logic         frm_fmt = 1'b0;
  logic         node_load = 1'b0;
  logic [W-1:0] node_addr_d = '0;
  logic [W-1:0] node_mask_d = '0;
  logic         frm_valid = 1'b0;
  logic         frm_ready;
  logic [W-1:0] frm_byte = '0;
  logic         frm_tag = 1'b0;
  logic         rx_flag;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sar_addr_filter #(.DATA_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .mp_en(mp_en), .frm_fmt(frm_fmt),
    .node_load(node_load), .node_addr_d(node_addr_d), .node_mask_d(node_mask_d),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_byte(frm_byte),
    .frm_tag(frm_tag), .rx_flag(rx_flag)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic set_node(input logic [W-1:0] a, input logic [W-1:0] m);
    @(negedge clk);
    node_addr_d = a; node_mask_d = m; node_load = 1'b1;
    @(negedge clk);
    node_load = 1'b0;
  endtask

  // drive one frame, then sample the flag in the following cycle
  task automatic send(input string req, input logic [W-1:0] b, input logic t, input logic exp);
    @(negedge clk);
    frm_byte = b; frm_tag = t; frm_valid = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0;
    check(req, rx_flag, exp);
  endtask

  task automatic t_reset;
    check("R1 flag", rx_flag, 1'b0);
    mp_en = 1'b1; frm_fmt = 1'b0;
    send("R1 any address", 8'h5A, 1'b1, 1'b1);
    send("R1 any address", 8'h00, 1'b1, 1'b1);
  endtask

  task automatic t_exact;
    set_node(8'hA4, 8'hFF);
    mp_en = 1'b1; frm_fmt = 1'b0;
    send("R5 exact hit", 8'hA4, 1'b1, 1'b1);
    send("R5 one bit off", 8'hA5, 1'b1, 1'b0);
    send("R5 miss", 8'h24, 1'b1, 1'b0);
    send("R6 broadcast FF", 8'hFF, 1'b1, 1'b1);
  endtask

  task automatic t_masked;
    set_node(8'hA4, 8'hF0);
    send("R4 dont-care nibble", 8'hA7, 1'b1, 1'b1);
    send("R4 dont-care nibble", 8'hA0, 1'b1, 1'b1);
    send("R4 upper miss", 8'hB4, 1'b1, 1'b0);
    send("R6 broadcast F4", 8'hF4, 1'b1, 1'b1);
    send("R6 broadcast F7", 8'hF7, 1'b1, 1'b1);
    send("R6 no hit", 8'h74, 1'b1, 1'b0);
  endtask

  task automatic t_data;
    set_node(8'hA4, 8'hFF);
    mp_en = 1'b1; frm_fmt = 1'b0;
    send("R3 data frame", 8'h33, 1'b0, 1'b1);
  endtask

  task automatic t_stop;
    mp_en = 1'b1; frm_fmt = 1'b1;
    send("R7 hit good stop", 8'hA4, 1'b1, 1'b1);
    send("R7 hit bad stop", 8'hA4, 1'b0, 1'b0);
    send("R7 miss good stop", 8'h33, 1'b1, 1'b0);
  endtask

  task automatic t_open;
    mp_en = 1'b0;
    frm_fmt = 1'b0;
    send("R2 open nine-bit", 8'h33, 1'b1, 1'b1);
    frm_fmt = 1'b1;
    send("R2 open bad stop", 8'h33, 1'b0, 1'b1);
  endtask

  task automatic t_pulse;
    mp_en = 1'b1; frm_fmt = 1'b0;
    send("R8 hit", 8'hA4, 1'b1, 1'b1);
    @(negedge clk);
    check("R8 pulse ends", rx_flag, 1'b0);
    check("R9 ready", frm_ready, 1'b1);
  endtask

  task automatic t_load_race;
    mp_en = 1'b1; frm_fmt = 1'b0;
    @(negedge clk);
    node_addr_d = 8'h5C; node_mask_d = 8'hFF; node_load = 1'b1;
    frm_byte = 8'h5C; frm_tag = 1'b1; frm_valid = 1'b1;
    @(negedge clk);
    node_load = 1'b0; frm_valid = 1'b0;
    check("R10 old identity", rx_flag, 1'b0);
    send("R10 new identity", 8'h5C, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exact();
    t_masked();
    t_data();
    t_stop();
    t_open();
    t_pulse();
    t_load_race();
    done = 1'b1;
  end

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    while (!done && cyc < 20000) @(negedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule